// File: doc/BRIEF.md
# Register Rename Table with Branch Recovery

This block renames one instruction per cycle for an out-of-order core. It maps a small set of architectural registers onto a larger pool of physical result registers. For every rename it looks up the current mapping of two source operands, hands out a fresh physical register for the destination, and records which architectural register that physical register stands for. Each physical register carries a ready bit. Allocation clears the bit and a writeback sets it. A source that has no in-flight producer is served straight from the committed architectural file.

Commit copies a physical value into its architectural register and returns the physical register to the free pool. The mapping entry is dropped only when no younger writer has taken it over. Every renamed branch saves a snapshot of the mapping and of the free-pool read position. Branches resolve oldest first. A correct resolution discards the oldest snapshot. A mispredict puts that snapshot back, discards every younger one, and gives the registers allocated after the branch back to the pool, in the order they were handed out.

Lookups and the offered destination tag are combinational on the current state. Every state change takes effect at the next rising clock edge.

Top module: `rrt_rename_table`

## Requirements
- R1: After reset no architectural register is mapped, every architectural value is 0, and the free pool holds all 32 physical registers in index order 0 to 31.
- R2: A source reports mapped=1 and the tag of the youngest renamed, not yet committed writer of that architectural register. The lookup sees the table as it was before the same instruction's own destination is renamed.
- R3: A source with no mapping reports mapped=0, ready=1 and the committed architectural value as its data.
- R4: `ren_dst_tag` always shows the oldest entry of the free pool. A rename with a destination takes that entry, and released registers join the back of the pool.
- R5: A rename stalls (`ren_stall`=1) when it needs a destination and the pool is empty, or when it is a branch and 4 snapshots are already held. A stalled rename changes no state.
- R6: Allocation clears a physical register's ready bit and a writeback sets it, both from the next cycle. The ready bit is not bypassed within the same cycle. A mapped source reports that bit as ready, and once ready its data is the written value.
- R7: A writeback changes only the physical register. The architectural value of that register stays unchanged until commit.
- R8: A commit copies the physical value into the architectural register recorded at allocation, visible from the next cycle, and appends the physical register to the pool.
- R9: A commit removes a mapping, whether live or held in a snapshot, only when that mapping still names the committing physical register.
- R10: A renamed branch saves one snapshot. Resolutions apply to the oldest unresolved branch, and a correct one frees its snapshot.
- R11: A mispredict restores the mapping as it stood right after the branch was renamed, minus later commit removals. It puts the registers allocated after the branch back at the head of the pool in allocation order, discards all snapshots, and drops any rename offered in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ren_valid | input | 1 | A rename is offered this cycle |
| ren_dst_valid | input | 1 | The offered instruction writes a destination |
| ren_dst | input | 3 | Architectural destination |
| ren_is_branch | input | 1 | The offered instruction is a branch (takes a snapshot) |
| ren_src_a | input | 3 | First architectural source |
| ren_src_b | input | 3 | Second architectural source |
| ren_stall | output | 1 | The offered rename cannot be accepted |
| ren_dst_tag | output | 5 | Physical register that the next destination rename receives |
| src_a_mapped | output | 1 | First source has an in-flight producer |
| src_a_tag | output | 5 | Physical tag of the first source's producer |
| src_a_ready | output | 1 | First source value is available |
| src_a_data | output | 16 | First source value |
| src_b_mapped | output | 1 | Second source has an in-flight producer |
| src_b_tag | output | 5 | Physical tag of the second source's producer |
| src_b_ready | output | 1 | Second source value is available |
| src_b_data | output | 16 | Second source value |
| wb_valid | input | 1 | A result is written back |
| wb_tag | input | 5 | Physical register written back |
| wb_data | input | 16 | Result value |
| cm_valid | input | 1 | The oldest instruction commits |
| cm_tag | input | 5 | Physical register of the committing instruction |
| br_valid | input | 1 | The oldest unresolved branch resolves |
| br_mispredict | input | 1 | That branch was mispredicted |

## Verification
The bench drives phases that fill the free pool and the snapshot store until both stall, and then phases that drain them. Along the way it meets commits of registers whose architectural name was already renamed again. A design that cleared the mapping without checking the tag would send later readers to stale committed data. Mispredicts land while commits are still freeing registers at the back of the pool. A design that failed to rewind the pool or to reclaim the flushed registers would hand out tags in a different order, or lose registers until the pool starved. Commits that strip tags out of saved snapshots are checked after restores: a missed update would bring back a mapping to a register that is already free. The same-cycle cases are also exercised: a rename during a mispredict, a lookup of a tag written back in that same cycle, and a source equal to the destination.

// File: rtl/rrt_pkg.sv
package rrt_pkg;
  localparam int RRT_ARCH_REGS = 8;
  localparam int RRT_PHYS_REGS = 32;
  localparam int RRT_DATA_W    = 16;
  localparam int RRT_SNAPSHOTS = 4;

  // a source is usable if nobody in flight produces it or its producer wrote
  function automatic logic src_is_ready(input logic mapped, input logic rdy);
    return !mapped || rdy;
  endfunction

  // an entry is hit when it is live and its tag compares equal
  function automatic logic slot_hit(input logic live, input logic tag_eq);
    return live && tag_eq;
  endfunction
endpackage

// File: rtl/rrt_free_pool.sv
module rrt_free_pool #(
  parameter int NPHYS = 32,
  parameter int PW    = $clog2(NPHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pop,
  input  logic          push,
  input  logic [PW-1:0] push_tag,
  input  logic          restore,
  input  logic [PW:0]   restore_head,
  output logic [PW-1:0] head_tag,
  output logic [PW:0]   head_ptr,
  output logic          empty
);
  logic [PW-1:0] slot_q [NPHYS];
  logic [PW:0]   head_q, tail_q, fill;

  assign fill     = tail_q - head_q;
  assign empty    = (fill == '0);
  assign head_tag = slot_q[head_q[PW-1:0]];
  assign head_ptr = head_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPHYS; i++) slot_q[i] <= PW'(i);
      head_q <= '0;
      tail_q <= (PW+1)'(NPHYS);
    end else begin
      if (push) begin
        slot_q[tail_q[PW-1:0]] <= push_tag;
        tail_q <= tail_q + 1'b1;
      end
      if (restore)  head_q <= restore_head;
      else if (pop) head_q <= head_q + 1'b1;
    end
  end

  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !restore |-> !empty);
  p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    push && !restore |-> fill < (PW+1)'(NPHYS));
endmodule

// File: rtl/rrt_snapshot_fifo.sv
module rrt_snapshot_fifo #(
  parameter int NARCH = 8,
  parameter int NPHYS = 32,
  parameter int NSNAP = 4,
  parameter int AW    = $clog2(NARCH),
  parameter int PW    = $clog2(NPHYS),
  parameter int CW    = $clog2(NSNAP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic          take_v   [NARCH],
  input  logic [PW-1:0] take_t   [NARCH],
  input  logic [PW:0]   take_head,
  input  logic          release_ok,
  input  logic          flush,
  input  logic          clr_valid,
  input  logic [AW-1:0] clr_arch,
  input  logic [PW-1:0] clr_tag,
  output logic          full,
  output logic          empty,
  output logic          old_v    [NARCH],
  output logic [PW-1:0] old_t    [NARCH],
  output logic [PW:0]   old_head
);
  import rrt_pkg::*;
  logic          sv_q [NSNAP][NARCH];
  logic [PW-1:0] st_q [NSNAP][NARCH];
  logic [PW:0]   sh_q [NSNAP];
  logic [CW:0]   rd_q, wr_q, used;

  assign used     = wr_q - rd_q;
  assign full     = (used == (CW+1)'(NSNAP));
  assign empty    = (used == '0);
  assign old_head = sh_q[rd_q[CW-1:0]];

  always_comb begin
    for (int i = 0; i < NARCH; i++) begin
      old_v[i] = sv_q[rd_q[CW-1:0]][i];
      old_t[i] = st_q[rd_q[CW-1:0]][i];
    end
  end

  for (genvar k = 0; k < NSNAP; k++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < NARCH; i++) begin
          sv_q[k][i] <= 1'b0;
          st_q[k][i] <= '0;
        end
        sh_q[k] <= '0;
      end else if (take && wr_q[CW-1:0] == CW'(k)) begin
        for (int i = 0; i < NARCH; i++) begin
          sv_q[k][i] <= take_v[i];
          st_q[k][i] <= take_t[i];
        end
        sh_q[k] <= take_head;
      end else if (clr_valid &&
                   slot_hit(sv_q[k][clr_arch], st_q[k][clr_arch] == clr_tag)) begin
        sv_q[k][clr_arch] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q <= '0;
      wr_q <= '0;
    end else if (flush) begin
      rd_q <= wr_q;
    end else begin
      if (release_ok) rd_q <= rd_q + 1'b1;
      if (take)       wr_q <= wr_q + 1'b1;
    end
  end

  p_take_room_r10: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !full && !flush);
  p_resolve_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (release_ok || flush) |-> !empty);
  p_flush_drops_all_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

// File: rtl/rrt_rename_table.sv
module rrt_rename_table
  import rrt_pkg::*;
#(
  parameter int NARCH = RRT_ARCH_REGS,
  parameter int NPHYS = RRT_PHYS_REGS,
  parameter int DW    = RRT_DATA_W,
  parameter int NSNAP = RRT_SNAPSHOTS,
  parameter int AW    = $clog2(NARCH),
  parameter int PW    = $clog2(NPHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ren_valid,
  input  logic          ren_dst_valid,
  input  logic [AW-1:0] ren_dst,
  input  logic          ren_is_branch,
  input  logic [AW-1:0] ren_src_a,
  input  logic [AW-1:0] ren_src_b,
  output logic          ren_stall,
  output logic [PW-1:0] ren_dst_tag,
  output logic          src_a_mapped,
  output logic [PW-1:0] src_a_tag,
  output logic          src_a_ready,
  output logic [DW-1:0] src_a_data,
  output logic          src_b_mapped,
  output logic [PW-1:0] src_b_tag,
  output logic          src_b_ready,
  output logic [DW-1:0] src_b_data,
  input  logic          wb_valid,
  input  logic [PW-1:0] wb_tag,
  input  logic [DW-1:0] wb_data,
  input  logic          cm_valid,
  input  logic [PW-1:0] cm_tag,
  input  logic          br_valid,
  input  logic          br_mispredict
);
  localparam int NSRC = 2;

  logic          map_v_q [NARCH];
  logic [PW-1:0] map_t_q [NARCH];
  logic          ready_q [NPHYS];
  logic [DW-1:0] prf_q   [NPHYS];
  logic [AW-1:0] owner_q [NPHYS];
  logic [DW-1:0] arch_q  [NARCH];

  // named events for the checks
  logic          flush, br_ok, ren_fire, alloc_fire, snap_take;
  logic [AW-1:0] cm_arch;
  logic [PW-1:0] head_tag;
  logic [PW:0]   head_ptr, snap_old_head;
  logic          pool_empty, snap_full, snap_empty;
  logic          snap_old_v [NARCH];
  logic [PW-1:0] snap_old_t [NARCH];
  logic          base_v [NARCH], map_nv [NARCH];
  logic [PW-1:0] base_t [NARCH], map_nt [NARCH];

  assign flush      = br_valid && br_mispredict;
  assign br_ok      = br_valid && !br_mispredict;
  assign ren_stall  = (ren_dst_valid && pool_empty) || (ren_is_branch && snap_full);
  assign ren_fire   = ren_valid && !ren_stall && !flush;
  assign alloc_fire = ren_fire && ren_dst_valid;
  assign snap_take  = ren_fire && ren_is_branch;
  assign cm_arch    = owner_q[cm_tag];
  assign ren_dst_tag = head_tag;

  // next mapping: restore, then commit removal, then the new destination
  always_comb begin
    for (int i = 0; i < NARCH; i++) begin
      base_v[i] = flush ? snap_old_v[i] : map_v_q[i];
      base_t[i] = flush ? snap_old_t[i] : map_t_q[i];
      map_nv[i] = base_v[i];
      map_nt[i] = base_t[i];
      if (cm_valid && AW'(i) == cm_arch && slot_hit(base_v[i], base_t[i] == cm_tag))
        map_nv[i] = 1'b0;
      if (alloc_fire && AW'(i) == ren_dst) begin
        map_nv[i] = 1'b1;
        map_nt[i] = head_tag;
      end
    end
  end

  // source lookup
  logic [AW-1:0] s_idx [NSRC];
  logic          s_map [NSRC];
  logic [PW-1:0] s_tag [NSRC];
  logic          s_rdy [NSRC];
  logic [DW-1:0] s_dat [NSRC];
  assign s_idx[0] = ren_src_a;
  assign s_idx[1] = ren_src_b;
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign s_map[g] = map_v_q[s_idx[g]];
    assign s_tag[g] = map_t_q[s_idx[g]];
    assign s_rdy[g] = src_is_ready(s_map[g], ready_q[s_tag[g]]);
    assign s_dat[g] = s_map[g] ? prf_q[s_tag[g]] : arch_q[s_idx[g]];
  end
  assign src_a_mapped = s_map[0];
  assign src_a_tag    = s_tag[0];
  assign src_a_ready  = s_rdy[0];
  assign src_a_data   = s_dat[0];
  assign src_b_mapped = s_map[1];
  assign src_b_tag    = s_tag[1];
  assign src_b_ready  = s_rdy[1];
  assign src_b_data   = s_dat[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPHYS; i++) begin
        ready_q[i] <= 1'b0;
        prf_q[i]   <= '0;
        owner_q[i] <= '0;
      end
      for (int i = 0; i < NARCH; i++) begin
        map_v_q[i] <= 1'b0;
        map_t_q[i] <= '0;
        arch_q[i]  <= '0;
      end
    end else begin
      if (wb_valid) begin
        ready_q[wb_tag] <= 1'b1;
        prf_q[wb_tag]   <= wb_data;
      end
      if (alloc_fire) begin
        ready_q[head_tag] <= 1'b0;
        owner_q[head_tag] <= ren_dst;
      end
      if (cm_valid) arch_q[cm_arch] <= prf_q[cm_tag];
      for (int i = 0; i < NARCH; i++) begin
        map_v_q[i] <= map_nv[i];
        map_t_q[i] <= map_nt[i];
      end
    end
  end

  rrt_free_pool #(.NPHYS(NPHYS), .PW(PW)) u_pool (
    .clk(clk), .rst_n(rst_n),
    .pop(alloc_fire), .push(cm_valid), .push_tag(cm_tag),
    .restore(flush), .restore_head(snap_old_head),
    .head_tag(head_tag), .head_ptr(head_ptr), .empty(pool_empty)
  );

  rrt_snapshot_fifo #(.NARCH(NARCH), .NPHYS(NPHYS), .NSNAP(NSNAP),
                      .AW(AW), .PW(PW)) u_snap (
    .clk(clk), .rst_n(rst_n),
    .take(snap_take), .take_v(map_nv), .take_t(map_nt),
    .take_head(head_ptr + {{PW{1'b0}}, alloc_fire}),
    .release_ok(br_ok), .flush(flush),
    .clr_valid(cm_valid), .clr_arch(cm_arch), .clr_tag(cm_tag),
    .full(snap_full), .empty(snap_empty),
    .old_v(snap_old_v), .old_t(snap_old_t), .old_head(snap_old_head)
  );

  p_alloc_unready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire |=> !ready_q[$past(head_tag)]);
  p_wb_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid && !(alloc_fire && head_tag == wb_tag) |=> ready_q[$past(wb_tag)]);
  p_commit_copies_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid |=> arch_q[$past(cm_arch)] == $past(prf_q[cm_tag]));
  p_commit_unmaps_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid && !flush && !(alloc_fire && ren_dst == cm_arch)
    |=> !(map_v_q[$past(cm_arch)] && map_t_q[$past(cm_arch)] == $past(cm_tag)));
  p_mispredict_held_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !snap_empty);
endmodule

// File: tb/rrt_rename_table_tb.sv
module rrt_rename_table_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NA = 8, NP = 32, DW = 16, NC = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic ren_valid = 0, ren_dst_valid = 0, ren_is_branch = 0;
  logic [2:0] ren_dst = 0, ren_src_a = 0, ren_src_b = 0;
  logic ren_stall; logic [4:0] ren_dst_tag;
  logic src_a_mapped, src_a_ready, src_b_mapped, src_b_ready;
  logic [4:0] src_a_tag, src_b_tag; logic [15:0] src_a_data, src_b_data;
  logic wb_valid = 0, cm_valid = 0, br_valid = 0, br_mispredict = 0;
  logic [4:0] wb_tag = 0, cm_tag = 0; logic [15:0] wb_data = 0;

  rrt_rename_table u_dut (.*);

  int compared = 0, mismatched = 0;
  string req_override = "";

  // reference model state
  typedef bit mvec_t [NA];
  typedef int tvec_t [NA];
  int fq[$], alog[$], ckn[$];
  mvec_t ckv[$]; tvec_t ckt[$];
  mvec_t mv; tvec_t mt;
  bit rdy[NP]; bit wrtn[NP]; int parch[NP];
  logic [15:0] prf[NP]; logic [15:0] arch[NA];
  bit prev_flush = 0, prev_commit = 0, prev_wb = 0;
  int fk[$], ft[$];  // in-flight program order: kind 1 = branch

  task automatic chk(input string what, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    string r;
    r = (req_override != "") ? req_override : req;
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", r, what, act, exp, $time);
    end
  endtask

  task automatic run_cycle(input bit rv, dv, input int dst, sa, sb, input bit br, wv,
                           input int wt, wd, input bit cv, input int ct,
                           input bit bv, bm, output bit acc, output int atag);
    bit stall_e, fl;
    @(negedge clk);
    ren_valid = rv; ren_dst_valid = dv; ren_dst = 3'(dst); ren_is_branch = br;
    ren_src_a = 3'(sa); ren_src_b = 3'(sb);
    wb_valid = wv; wb_tag = 5'(wt); wb_data = 16'(wd);
    cm_valid = cv; cm_tag = 5'(ct); br_valid = bv; br_mispredict = bm;
    #1;
    stall_e = (dv && fq.size() == 0) || (br && ckv.size() == NC);
    chk("stall", br ? "R10" : "R5", ren_stall, stall_e);
    if (fq.size() > 0) chk("dst_tag", prev_flush ? "R11" : "R4", ren_dst_tag, fq[0]);
    for (int s = 0; s < 2; s++) begin
      int idx; logic m, rd; logic [4:0] tg; logic [15:0] dt; string lm, ld;
      idx = s ? sb : sa;
      m  = s ? src_b_mapped : src_a_mapped; tg = s ? src_b_tag : src_a_tag;
      rd = s ? src_b_ready : src_a_ready;   dt = s ? src_b_data : src_a_data;
      lm = prev_flush ? "R11" : (prev_commit ? "R9" : "R2");
      chk("src_mapped", lm, m, mv[idx]);
      if (mv[idx]) chk("src_tag", lm, tg, mt[idx]);
      chk("src_ready", mv[idx] ? "R6" : "R3", rd, !mv[idx] || rdy[mt[idx]]);
      ld = mv[idx] ? "R6" : (prev_commit ? "R8" : (prev_wb ? "R7" : "R3"));
      if (!mv[idx]) chk("src_data", ld, dt, arch[idx]);
      else if (rdy[mt[idx]]) chk("src_data", ld, dt, prf[mt[idx]]);
    end
    // model update for the coming edge
    fl = bv && bm;
    if (fl) begin
      for (int i = alog.size() - 1; i >= ckn[0]; i--) fq.push_front(alog[i]);
      while (alog.size() > ckn[0]) void'(alog.pop_back());
      mv = ckv[0]; mt = ckt[0];
      ckv.delete(); ckt.delete(); ckn.delete();
    end else if (bv) begin
      void'(ckv.pop_front()); void'(ckt.pop_front()); void'(ckn.pop_front());
    end
    if (cv) begin
      int a; a = parch[ct];
      arch[a] = prf[ct];
      if (mv[a] && mt[a] == ct) mv[a] = 0;
      foreach (ckv[k]) if (ckv[k][a] && ckt[k][a] == ct) ckv[k][a] = 0;
      fq.push_back(ct);
    end
    if (wv) begin rdy[wt] = 1; prf[wt] = 16'(wd); wrtn[wt] = 1; end
    acc = rv && !stall_e && !fl;
    atag = -1;
    if (acc && dv) begin
      atag = fq.pop_front(); alog.push_back(atag);
      rdy[atag] = 0; wrtn[atag] = 0; parch[atag] = dst;
      mv[dst] = 1; mt[dst] = atag;
    end
    if (acc && br) begin ckv.push_back(mv); ckt.push_back(mt); ckn.push_back(alog.size()); end
    prev_flush = fl; prev_commit = cv; prev_wb = wv;
  endtask

  task automatic rand_cycle(input int p_ren, p_cm, p_wb);
    bit rv, dv, br, wv, cv, bv, bm, acc; int dst, sa, sb, wt, wd, ct, atag;
    int cand[$];
    rv = 0; dv = 0; br = 0; wv = 0; cv = 0; bv = 0; bm = 0;
    dst = 0; wt = 0; wd = 0; ct = 0;
    sa = $urandom_range(NA-1, 0); sb = $urandom_range(NA-1, 0);
    if ($urandom_range(99, 0) < p_ren) begin
      rv = 1;
      if ($urandom_range(99, 0) < 20) br = 1;
      else begin dv = 1; dst = $urandom_range(NA-1, 0); end
    end
    if (fk.size() > 0) begin
      if (fk[0] == 1) begin
        if ($urandom_range(99, 0) < p_cm) begin bv = 1; bm = ($urandom_range(99, 0) < 35); end
      end else if (wrtn[ft[0]] && $urandom_range(99, 0) < p_cm) begin
        cv = 1; ct = ft[0];
      end
    end
    if ($urandom_range(99, 0) < p_wb) begin
      foreach (fk[i]) if (fk[i] == 0 && !wrtn[ft[i]]) cand.push_back(ft[i]);
      if (cand.size() > 0) begin
        wv = 1; wt = cand[$urandom_range(cand.size() - 1, 0)]; wd = $urandom_range(65535, 0);
      end
    end
    run_cycle(rv, dv, dst, sa, sb, br, wv, wt, wd, cv, ct, bv, bm, acc, atag);
    if (bv && bm) begin fk.delete(); ft.delete(); end
    else if (bv || cv) begin void'(fk.pop_front()); void'(ft.pop_front()); end
    if (acc) begin fk.push_back(br ? 1 : 0); ft.push_back(br ? -1 : atag); end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    mismatched++;
    $display("FAIL watchdog: run did not end");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    bit acc; int atag;
    for (int i = 0; i < NP; i++) begin fq.push_back(i); rdy[i] = 0; prf[i] = 0; parch[i] = 0; wrtn[i] = 0; end
    for (int i = 0; i < NA; i++) begin mv[i] = 0; mt[i] = 0; arch[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1: reset state, every source unmapped with value 0, pool head at tag 0
    req_override = "R1";
    for (int s = 0; s < NA; s++) run_cycle(0, 0, 0, s, NA-1-s, 0, 0, 0, 0, 0, 0, 0, 0, acc, atag);
    req_override = "";
    // fill phase: pool empty and snapshot-full stalls (R5, R10)
    repeat (600) rand_cycle(90, 10, 50);
    // mixed phase: commits over remapped names (R9), mispredicts under traffic (R11)
    repeat (3000) rand_cycle(50, 60, 60);
    // drain phase: committed values read back from the architectural file (R8, R3)
    repeat (400) rand_cycle(10, 90, 90);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule